// File: doc/BRIEF.md
# SDRAM Device-Side Command Decoder and State Tracker

This block watches the control pins of a single-data-rate SDRAM interface from the memory side. It samples them on each rising clock edge and resolves them into one command. Resolving a command takes the clock-enable level at this edge, the clock-enable level seen at the edge before, the per-bank open/closed state and the device power state. It reports the command, its bank, its address, whether auto precharge was requested and whether the command was out of place. It keeps the bank and power bookkeeping that a memory model or protocol monitor needs: four banks, each closed or open, and a device that is running, clock-suspended, powered down or in self refresh.

A programmed burst length decides how long a read or write burst is in progress. The block counts the burst down, and the count stops while the internal clock is held. The block uses that count for three things. It turns a power-down request made during a burst into a clock suspend. It decides whether a burst-stop command is meaningful. It gates the per-lane read output. The per-lane data mask pins drive a write-mask output and a read-output-off output.

Top module: `sdr_cmd_tracker`

## Requirements
- R1: All outputs change one clock after the edge that sampled the pins. With chip select high the command is deselect. With chip select low, {RAS#,CAS#,WE#} decodes as follows: 111 no-op, 110 burst stop, 011 activate, 010 precharge (all banks when A10 is high), 100 write, 101 read, 000 mode set, 001 refresh.
- R2: Activate is legal only to a closed bank. It opens that bank, and addr_o carries the row address.
- R3: Read and write are legal only to an open bank. addr_o carries the column, which is the low COL_W address bits zero-extended. ap_o equals A10. With A10 high the bank is closed by the command itself.
- R4: Precharge with A10 low closes only the selected bank. With A10 high it closes every bank, and the bank bits have no effect.
- R5: Mode set and refresh (with CKE high at both edges) are legal only when all banks are closed. Mode set stores address bits [2:0] as the burst code: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives full page, and any other code gives 1. After reset the code is 0.
- R6: A legal read or write starts a burst of the programmed length. The burst counts down once per edge at which the previous CKE was high. A full-page burst does not count down. Burst stop is legal only while a burst is in progress, and it ends the burst.
- R7: Falling CKE with deselect or no-op enters power down when no burst is in progress. When a burst is in progress it enters clock suspend instead. The burst count holds at every edge whose previous CKE was low.
- R8: Falling CKE with the refresh encoding enters self refresh only when all banks are closed and no burst is running. Otherwise it is illegal.
- R9: When CKE is low at both edges the command is NONE and nothing changes. Rising CKE with deselect or no-op reports EXIT. Rising CKE with any other command is illegal and is not executed. Either way the device returns to normal.
- R10: An illegal command raises illegal_o for that one result cycle. It leaves the bank, burst and mode state unchanged.
- R11: wmask_o equals the DQM lanes sampled at the previous edge. rd_off_o equals those lanes ORed with "no burst in progress".
- R12: During and after reset all banks are closed, the device is normal, cmd_o is deselect, illegal_o and ap_o are 0, and wmask_o and rd_off_o are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| addr | input | ADDR_W | Address bus (bit AP_BIT selects auto/all precharge) |
| dqm | input | LANES | Per-lane data mask |
| cmd_o | output | 5 | Decoded command code (package enum) |
| bank_o | output | BA_W | Bank bits of the command |
| addr_o | output | ADDR_W | Row, column or op code |
| ap_o | output | 1 | Auto precharge requested |
| illegal_o | output | 1 | Command not legal in current state |
| wmask_o | output | LANES | Write data mask per lane |
| rd_off_o | output | LANES | Read output disabled per lane |

## Verification
The bench keeps the default parameters: an 11-bit address with A10 as the precharge-all and auto-precharge bit, an 8-bit column, four banks and four mask lanes. Because the column is narrower than the address, read addresses with bits 9 and 8 set expose whether the column is truncated. The 256-beat full-page length is far longer than any short run, so a full-page burst is checked by showing that it is still busy after twenty cycles and then ends on burst stop. The sequences drive the 4-beat and 1-beat bursts, including a power-down request on the last beat of a 1-beat burst, to their exact ends.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;

  typedef enum logic [4:0] {
    CMD_NONE     = 5'd0,
    CMD_DESEL    = 5'd1,
    CMD_NOP      = 5'd2,
    CMD_BST      = 5'd3,
    CMD_ACT      = 5'd4,
    CMD_PRE      = 5'd5,
    CMD_PREA     = 5'd6,
    CMD_WR       = 5'd7,
    CMD_RD       = 5'd8,
    CMD_MRS      = 5'd9,
    CMD_AREF     = 5'd10,
    CMD_SREF_IN  = 5'd11,
    CMD_PD_IN    = 5'd12,
    CMD_CSUSP_IN = 5'd13,
    CMD_EXIT     = 5'd14
  } cmd_e;

  typedef enum logic [1:0] {
    DEV_NORM  = 2'd0,
    DEV_SUSP  = 2'd1,
    DEV_PDOWN = 2'd2,
    DEV_SREF  = 2'd3
  } dev_e;

endpackage

// File: rtl/sdr_pin_decode.sv
module sdr_pin_decode
  import sdr_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic all_bit,
  output cmd_e raw_cmd
);

  always_comb begin
    if (cs_n) begin
      raw_cmd = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  raw_cmd = CMD_NOP;
        3'b110:  raw_cmd = CMD_BST;
        3'b011:  raw_cmd = CMD_ACT;
        3'b010:  raw_cmd = all_bit ? CMD_PREA : CMD_PRE;
        3'b100:  raw_cmd = CMD_WR;
        3'b101:  raw_cmd = CMD_RD;
        3'b000:  raw_cmd = CMD_MRS;
        default: raw_cmd = CMD_AREF;
      endcase
    end
  end

endmodule

// File: rtl/sdr_bank_state.sv
module sdr_bank_state #(
  parameter int NBANK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] open_set,
  input  logic [NBANK-1:0] close_set,
  output logic [NBANK-1:0] bank_open
);

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic open_n;

    always_comb begin
      open_n = bank_open[i];
      if (open_set[i])       open_n = 1'b1;
      else if (close_set[i]) open_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_open[i] <= 1'b0;
      else        bank_open[i] <= open_n;
    end
  end

  // R2
  open_close_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_set & close_set) == '0);

endmodule

// File: rtl/sdr_burst_count.sv
module sdr_burst_count #(
  parameter int COL_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic       stop,
  input  logic       mode_wr,
  input  logic [2:0] mode_code,
  output logic       busy
);

  localparam int CNT_W    = COL_W + 1;
  localparam int FULL_LEN = 2 ** COL_W;

  logic [2:0]       code_q, code_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, len;
  logic             full_pg;

  assign full_pg = (code_q == 3'd7);

  always_comb begin
    unique case (code_q)
      3'd1:    len = CNT_W'(2);
      3'd2:    len = CNT_W'(4);
      3'd3:    len = CNT_W'(8);
      3'd7:    len = CNT_W'(FULL_LEN);
      default: len = CNT_W'(1);
    endcase
  end

  always_comb begin
    code_n = mode_wr ? mode_code : code_q;
    cnt_n  = cnt_q;
    if (stop)                                    cnt_n = '0;
    else if (load)                               cnt_n = len;
    else if (tick && (cnt_q != '0) && !full_pg)  cnt_n = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= 3'd0;
      cnt_q  <= '0;
    end else begin
      code_q <= code_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy = (cnt_q != '0);

  // R7
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

endmodule

// File: rtl/sdr_cmd_tracker.sv
module sdr_cmd_tracker
  import sdr_trk_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int COL_W  = 8,
  parameter int BA_W   = 2,
  parameter int LANES  = 4,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  dqm,
  output logic [4:0]        cmd_o,
  output logic [BA_W-1:0]   bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ap_o,
  output logic              illegal_o,
  output logic [LANES-1:0]  wmask_o,
  output logic [LANES-1:0]  rd_off_o
);

  localparam int NBANK = 2 ** BA_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  cmd_e             raw, cmd_q, cmd_n;
  dev_e             dev_q, dev_n;
  logic             cke_q;
  logic [NBANK-1:0] bank_open, open_set, close_set, sel;
  logic             busy, load, stop, mode_wr, ill_n, ill_q, ap_n, ap_q;
  logic             all_closed, sel_open, quiet;
  logic [ADDR_W-1:0] addr_n, addr_q;
  logic [BA_W-1:0]  bank_q;
  logic [LANES-1:0] dqm_q;

  sdr_pin_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .all_bit(addr[AP_BIT]), .raw_cmd(raw)
  );

  sdr_bank_state #(.NBANK(NBANK)) u_banks (
    .clk(clk), .rst_n(rst_sn), .open_set(open_set),
    .close_set(close_set), .bank_open(bank_open)
  );

  sdr_burst_count #(.COL_W(COL_W)) u_burst (
    .clk(clk), .rst_n(rst_sn), .tick(cke_q), .load(load), .stop(stop),
    .mode_wr(mode_wr), .mode_code(addr[2:0]), .busy(busy)
  );

  assign sel        = NBANK'(1) << ba;
  assign all_closed = (bank_open == '0);
  assign sel_open   = bank_open[ba];
  assign quiet      = (raw == CMD_DESEL) || (raw == CMD_NOP);

  always_comb begin
    cmd_n     = raw;
    dev_n     = dev_q;
    ill_n     = 1'b0;
    ap_n      = 1'b0;
    addr_n    = addr;
    open_set  = '0;
    close_set = '0;
    load      = 1'b0;
    stop      = 1'b0;
    mode_wr   = 1'b0;
    unique case ({cke_q, cke})
      2'b00: cmd_n = CMD_NONE;
      2'b01: begin
        dev_n = DEV_NORM;
        if (quiet) cmd_n = CMD_EXIT;
        else       ill_n = 1'b1;
      end
      2'b10: begin
        if (raw == CMD_AREF) begin
          cmd_n = CMD_SREF_IN;
          if (all_closed && !busy) dev_n = DEV_SREF;
          else                     ill_n = 1'b1;
        end else if (quiet) begin
          cmd_n = busy ? CMD_CSUSP_IN : CMD_PD_IN;
          dev_n = busy ? DEV_SUSP : DEV_PDOWN;
        end else begin
          ill_n = 1'b1;
        end
      end
      default: begin
        unique case (raw)
          CMD_BST: begin
            if (busy) stop  = 1'b1;
            else      ill_n = 1'b1;
          end
          CMD_ACT: begin
            if (sel_open) ill_n    = 1'b1;
            else          open_set = sel;
          end
          CMD_PRE:  close_set = sel;
          CMD_PREA: close_set = '1;
          CMD_WR, CMD_RD: begin
            ap_n   = addr[AP_BIT];
            addr_n = ADDR_W'(addr[COL_W-1:0]);
            if (!sel_open) begin
              ill_n = 1'b1;
            end else begin
              load = 1'b1;
              if (addr[AP_BIT]) close_set = sel;
            end
          end
          CMD_MRS: begin
            if (all_closed) mode_wr = 1'b1;
            else            ill_n   = 1'b1;
          end
          CMD_AREF: begin
            if (!all_closed) ill_n = 1'b1;
          end
          default: ;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cke_q  <= 1'b1;
      dev_q  <= DEV_NORM;
      cmd_q  <= CMD_DESEL;
      bank_q <= '0;
      addr_q <= '0;
      ap_q   <= 1'b0;
      ill_q  <= 1'b0;
      dqm_q  <= '1;
    end else begin
      cke_q  <= cke;
      dev_q  <= dev_n;
      cmd_q  <= cmd_n;
      bank_q <= ba;
      addr_q <= addr_n;
      ap_q   <= ap_n;
      ill_q  <= ill_n;
      dqm_q  <= dqm;
    end
  end

  assign cmd_o     = cmd_q;
  assign bank_o    = bank_q;
  assign addr_o    = addr_q;
  assign ap_o      = ap_q;
  assign illegal_o = ill_q;
  assign wmask_o   = dqm_q;
  assign rd_off_o  = dqm_q | {LANES{~busy}};

  // R10
  ill_keep_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ill_q |-> bank_open == $past(bank_open));

  // R8
  sref_closed_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    dev_q == DEV_SREF |-> bank_open == '0);

  // R7
  pd_no_burst_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(dev_q == DEV_PDOWN) |-> !$past(busy));

endmodule

// File: tb/sim_sdr_cmd_tracker.sv
`timescale 1ns/1ps
module sim_sdr_cmd_tracker;
  import sdr_trk_pkg::*;

  localparam logic [3:0] P_DESEL = 4'b1111, P_NOP = 4'b0111, P_BST = 4'b0110,
                         P_ACT = 4'b0011, P_PRE = 4'b0010, P_WR = 4'b0100,
                         P_RD = 4'b0101, P_MRS = 4'b0000, P_REF = 4'b0001;

  typedef struct {
    cmd_e        cmd;
    logic        ill;
    logic        busy;
    logic        chk;
    logic        ap;
    logic [1:0]  ba;
    logic [10:0] addr;
    logic [3:0]  dqm;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [10:0] addr = '0;
  logic [3:0]  dqm = '1;
  logic [4:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [10:0] addr_o;
  logic        ap_o, illegal_o;
  logic [3:0]  wmask_o, rd_off_o;

  int   n_vec = 0, n_bad = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  sdr_cmd_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm),
    .cmd_o(cmd_o), .bank_o(bank_o), .addr_o(addr_o), .ap_o(ap_o),
    .illegal_o(illegal_o), .wmask_o(wmask_o), .rd_off_o(rd_off_o)
  );

  task automatic vec(input logic k, input logic [3:0] p, input logic [1:0] b,
                     input logic [10:0] a, input logic [3:0] d, input cmd_e ec,
                     input logic eill, input logic ebusy, input logic chk,
                     input logic eap, input logic [10:0] eaddr, input string tag);
    exp_t e;
    @(negedge clk);
    cke = k; {cs_n, ras_n, cas_n, we_n} = p; ba = b; addr = a; dqm = d;
    e.cmd = ec; e.ill = eill; e.busy = ebusy; e.chk = chk; e.ap = eap;
    e.ba = b; e.addr = eaddr; e.dqm = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic v(input logic k, input logic [3:0] p, input logic [1:0] b,
                   input logic [10:0] a, input cmd_e ec, input logic eill,
                   input logic ebusy, input string tag);
    vec(k, p, b, a, 4'h0, ec, eill, ebusy, 1'b0, 1'b0, 11'h0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        logic ok;
        logic [3:0] eoff;
        e = q.pop_front();
        eoff = e.dqm | {4{~e.busy}};
        ok = (cmd_o == e.cmd) && (illegal_o == e.ill) &&
             (wmask_o == e.dqm) && (rd_off_o == eoff);
        if (e.chk)
          ok = ok && (bank_o == e.ba) && (addr_o == e.addr) && (ap_o == e.ap);
        n_vec++;
        if (!ok) begin
          n_bad++;
          $display("FAIL %s: cmd=%0d/%0d ill=%0b/%0b wmask=%h/%h rdoff=%h/%h bank=%0d/%0d addr=%h/%h ap=%0b/%0b",
                   e.tag, cmd_o, e.cmd, illegal_o, e.ill, wmask_o, e.dqm,
                   rd_off_o, eoff, bank_o, e.ba, addr_o, e.addr, ap_o, e.ap);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    n_vec++;
    if (cmd_o != 5'(CMD_DESEL) || illegal_o || ap_o || wmask_o != 4'hF || rd_off_o != 4'hF) begin
      n_bad++;
      $display("FAIL R12: cmd=%0d/%0d ill=%0b/0 wmask=%h/f rdoff=%h/f",
               cmd_o, CMD_DESEL, illegal_o, wmask_o, rd_off_o);
    end

    v(1, P_DESEL, 0, 0, CMD_DESEL, 0, 0, "R1 deselect");
    v(1, P_RD,  0, 11'h0, CMD_RD,  1, 0, "R3 read to closed bank");
    v(1, P_MRS, 0, 11'h2, CMD_MRS, 0, 0, "R5 mode set BL4");
    vec(1, P_ACT, 1, 11'h155, 4'h0, CMD_ACT, 0, 0, 1, 0, 11'h155, "R2 activate row");
    v(1, P_ACT, 1, 11'h0, CMD_ACT, 1, 0, "R2 activate open bank");
    vec(1, P_RD, 1, 11'h32A, 4'b0101, CMD_RD, 0, 1, 1, 0, 11'h02A, "R3 R11 read column");
    v(1, P_NOP, 0, 0, CMD_NOP, 0, 1, "R6 burst running");
    v(0, P_NOP, 0, 0, CMD_CSUSP_IN, 0, 1, "R7 suspend during burst");
    v(0, P_NOP, 0, 0, CMD_NONE, 0, 1, "R9 cke held low");
    v(0, P_ACT, 2, 0, CMD_NONE, 0, 1, "R9 command ignored while low");
    v(1, P_NOP, 0, 0, CMD_EXIT, 0, 1, "R9 exit suspend, count held R7");
    v(1, P_BST, 0, 0, CMD_BST, 0, 0, "R6 burst stop");
    v(1, P_BST, 0, 0, CMD_BST, 1, 0, "R6 R10 stop with no burst");
    vec(1, P_WR, 1, 11'h405, 4'h0, CMD_WR, 0, 1, 1, 1, 11'h005, "R3 write auto precharge");
    v(1, P_RD, 1, 0, CMD_RD, 1, 1, "R3 bank closed by auto precharge");
    v(1, P_NOP, 0, 0, CMD_NOP, 0, 1, "R6 BL4 beat");
    v(1, P_NOP, 0, 0, CMD_NOP, 0, 1, "R6 BL4 beat");
    v(1, P_NOP, 0, 0, CMD_NOP, 0, 0, "R6 BL4 end");
    v(0, P_DESEL, 0, 0, CMD_PD_IN, 0, 0, "R7 power down");
    v(0, P_DESEL, 0, 0, CMD_NONE, 0, 0, "R9 low");
    v(1, P_ACT, 0, 0, CMD_ACT, 1, 0, "R9 rising cke with activate");
    v(1, P_ACT, 0, 0, CMD_ACT, 0, 0, "R9 R10 bank untouched by illegal");
    v(1, P_REF, 0, 0, CMD_AREF, 1, 0, "R5 refresh with open bank");
    v(1, P_MRS, 0, 11'h3, CMD_MRS, 1, 0, "R5 mode set with open bank");
    v(0, P_REF, 0, 0, CMD_SREF_IN, 1, 0, "R8 self refresh with open bank");
    v(1, P_NOP, 0, 0, CMD_EXIT, 0, 0, "R9 rise after refused entry");
    v(1, P_ACT, 2, 11'h7, CMD_ACT, 0, 0, "R2 open bank 2");
    v(1, P_ACT, 3, 11'h9, CMD_ACT, 0, 0, "R2 open bank 3");
    vec(1, P_PRE, 2, 11'h0, 4'h0, CMD_PRE, 0, 0, 1, 0, 11'h0, "R4 precharge one");
    v(1, P_ACT, 3, 0, CMD_ACT, 1, 0, "R4 bank 3 still open");
    v(1, P_ACT, 2, 0, CMD_ACT, 0, 0, "R4 bank 2 closed");
    v(1, P_PRE, 0, 11'h400, CMD_PREA, 0, 0, "R4 precharge all");
    v(1, P_RD, 3, 0, CMD_RD, 1, 0, "R4 bank 3 closed by all");
    v(1, P_REF, 0, 0, CMD_AREF, 0, 0, "R5 refresh all closed");
    v(0, P_REF, 0, 0, CMD_SREF_IN, 0, 0, "R8 self refresh entry");
    v(0, P_DESEL, 0, 0, CMD_NONE, 0, 0, "R9 in self refresh");
    v(1, P_DESEL, 0, 0, CMD_EXIT, 0, 0, "R9 self refresh exit");
    v(1, P_MRS, 0, 11'h7, CMD_MRS, 0, 0, "R5 full page");
    v(1, P_ACT, 0, 0, CMD_ACT, 0, 0, "R2 open bank 0");
    v(1, P_RD, 0, 0, CMD_RD, 0, 1, "R6 full page start");
    for (int i = 0; i < 20; i++) v(1, P_NOP, 0, 0, CMD_NOP, 0, 1, "R6 full page holds");
    v(1, P_BST, 0, 0, CMD_BST, 0, 0, "R6 full page stop");
    v(1, P_PRE, 0, 11'h400, CMD_PREA, 0, 0, "R4 close all");
    v(1, P_MRS, 0, 11'h0, CMD_MRS, 0, 0, "R5 BL1");
    v(1, P_ACT, 0, 0, CMD_ACT, 0, 0, "R2 open bank 0");
    v(1, P_RD, 0, 0, CMD_RD, 0, 1, "R6 BL1 read");
    v(0, P_NOP, 0, 0, CMD_CSUSP_IN, 0, 0, "R7 suspend on last beat");
    v(1, P_DESEL, 0, 0, CMD_EXIT, 0, 0, "R9 exit suspend");
    vec(1, P_NOP, 0, 0, 4'hA, CMD_NOP, 0, 0, 0, 0, 0, "R11 mask lanes idle");
    v(1, P_NOP, 0, 0, CMD_NOP, 0, 0, "R1 no-op");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule